// File: doc/BRIEF.md
# Multiplicative Reciprocal Iteration Unit

This block forms the reciprocal of a positive, normalized fraction (1/2 ≤ x < 1) without long division. It looks up a short starting estimate p from the leading bits of x. It then runs a fixed number of correction passes. Each pass builds a short correction factor from the next group of bits of the running product a = x·b. That one factor scales both a and the reciprocal estimate b. Because the error is roughly squared on every pass, three corrections take a 2^-5 starting error below 2^-38.

A pass that uses the quotient option adds one multiply of the finished reciprocal by a dividend y, which gives y/x. The caller presents the operands and pulses `start`. A one-cycle `done` pulse marks the point where `recip` and `quot` are valid. Both outputs then keep their values until the next accepted start. Operands are unsigned fractions with `FRAC_W` bits. Results carry two integer bits above `FRAC_W` fraction bits.

Top module: `recip_iter_unit`

## Requirements
- R1: After reset, `done` is 0 and both `recip` and `quot` read 0.
- R2: A start pulse is accepted when the unit is idle or in its `done` cycle. `done` then rises for exactly one cycle, 5 clock edges after the accepting edge when the quotient option is on (4 when it is off).
- R3: `divisor` is read as x = divisor/2^40 with bit 39 set, and `recip` is read as r = recip/2^40 (bits 41:40 integer). For every such x, |x·r − 1| < 2^-38.
- R4: The bound of R3 holds at both ends of the input range: x = 1/2 (only bit 39 set) and x = 1 − 2^-40 (all 40 bits set). It also holds at the first and last code of every 1/128-wide interval of x.
- R5: `dividend` is read as y = dividend/2^40, and `quot` is read as q = quot/2^40 (bits 41:40 integer). For any y in [0,1), |x·q − y| < 2^-37.
- R6: A start pulse while a computation is in progress is ignored. It changes neither the operand in use, nor the result, nor the cycle at which `done` rises, and it does not trigger a second `done`.
- R7: After `done`, `recip` and `quot` keep their values and `done` stays low until the next start is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a computation with the present operands |
| divisor | input | FRAC_W (40) | Normalized fraction x, MSB must be 1 |
| dividend | input | FRAC_W (40) | Fraction y for the optional quotient |
| recip | output | FRAC_W+2 (42) | Reciprocal 1/x, two integer bits |
| quot | output | FRAC_W+2 (42) | Quotient y/x, two integer bits (0 when the option is off) |
| done | output | 1 | One-cycle pulse: results valid |

## Verification
The hardest case to reach from the ports is the worst-case starting estimate: a divisor at the very edge of a lookup interval. There the seed error is largest and the later corrections have the least margin. The stimulus drives the first and last code of every one of the 64 intervals, the two range endpoints, and constrained-random normalized divisors. A second awkward case is a start pulse that arrives mid-computation. It is injected two cycles into a run, with a different divisor on the input, to show that the run in flight is undisturbed.

// File: rtl/recip_iter_pkg.sv
package recip_iter_pkg;

   // Sequencer phases; one multiply pass per phase.
   typedef enum logic [2:0] {
      PH_IDLE  = 3'd0,
      PH_SEED  = 3'd1,
      PH_CORR1 = 3'd2,
      PH_CORR2 = 3'd3,
      PH_CORR3 = 3'd4,
      PH_QUOT  = 3'd5,
      PH_DONE  = 3'd6
   } recip_phase_e;

   // Which correction pass the factor generator serves.
   typedef enum logic [1:0] {
      CSEL_FIRST  = 2'd0,
      CSEL_SECOND = 2'd1,
      CSEL_THIRD  = 2'd2
   } corr_sel_e;

endpackage

// File: rtl/recip_seed_rom.sv
// Starting estimate p ~ 1/x, indexed by the fraction bits after the
// always-set leading bit. Each entry is the rounded reciprocal of the
// interval midpoint, computed at elaboration time.
module recip_seed_rom #(
   parameter int IDX_W  = 7,   // leading fraction bits of x examined
   parameter int SEED_F = 6    // fraction bits of the estimate
) (
   input  logic [IDX_W-2:0] idx,
   output logic [SEED_F:0]  seed
);
   localparam int ROWS = 1 << (IDX_W - 1);
   localparam int SW   = SEED_F + 1;
   localparam int NUM  = 1 << (SEED_F + IDX_W + 1);

   logic [SW-1:0] tbl [ROWS];

   for (genvar g = 0; g < ROWS; g++) begin : g_row
      // interval [i/2^IDX_W, (i+1)/2^IDX_W), i = ROWS+g; midpoint (2i+1)/2^(IDX_W+1)
      localparam int DEN = 2 * (ROWS + g) + 1;
      assign tbl[g] = SW'((2 * NUM + DEN) / (2 * DEN));
   end

   assign seed = tbl[idx];

endmodule

// File: rtl/recip_corr_factor.sv
// Builds the shared correction factor m = 1 - floor(a - 1) where the
// floor keeps only resolution 2^-(2*acc), 2^-(4*acc) or 2^-(8*acc)
// depending on the pass. Only the next group of bits of a contributes.
module recip_corr_factor
   import recip_iter_pkg::*;
#(
   parameter int FW       = 60,
   parameter int SEED_ACC = 5
) (
   input  corr_sel_e     sel,
   input  logic [FW+1:0] run_prod,
   output logic [FW+1:0] factor
);
   localparam int IW = FW + 2;
   localparam logic [IW:0] ONE = (IW+1)'(1) << FW;

   logic signed [IW:0] dev;
   logic [IW:0]        kept [3];
   logic [IW:0]        pick;

   assign dev = $signed({1'b0, run_prod}) - $signed(ONE);

   for (genvar k = 0; k < 3; k++) begin : g_pass
      localparam int RES = SEED_ACC << (k + 1);
      localparam logic [IW:0] KEEP = {(IW+1){1'b1}} << (FW - RES);
      // two's-complement truncation rounds toward minus infinity
      assign kept[k] = dev & KEEP;
   end

   always_comb begin
      case (sel)
         CSEL_FIRST:  pick = kept[0];
         CSEL_SECOND: pick = kept[1];
         default:     pick = kept[2];
      endcase
   end

   assign factor = IW'(ONE - pick);

endmodule

// File: rtl/recip_fix_mul.sv
// Truncating unsigned fixed-point multiply: (a*b) >> SH, kept to OW bits.
module recip_fix_mul #(
   parameter int AW = 62,
   parameter int BW = 62,
   parameter int SH = 60,
   parameter int OW = 62
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          chk,
   input  logic [AW-1:0] op_a,
   input  logic [BW-1:0] op_b,
   output logic [OW-1:0] prod
);
   localparam int PW = AW + BW;

   if (SH + OW > PW) begin : g_bad_width
      $error("recip_fix_mul: SH + OW exceeds product width");
   end

   logic [PW-1:0] full;
   assign full = PW'(op_a) * PW'(op_b);
   assign prod = OW'(full >> SH);

   // R3: a result used by the sequencer never loses integer bits
   a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      chk |-> (((full >> SH) >> OW) == '0));

endmodule

// File: rtl/recip_iter_unit.sv
module recip_iter_unit
   import recip_iter_pkg::*;
#(
   parameter int FRAC_W    = 40,  // operand / result fraction bits
   parameter int WORK_F    = 60,  // internal fraction bits
   parameter int SEED_IDX  = 7,   // leading bits of x used by the table
   parameter int SEED_F    = 6,   // fraction bits of the estimate
   parameter int SEED_ACC  = 5,   // estimate guarantees |x*p-1| < 2^-SEED_ACC
   parameter int WITH_QUOT = 1    // 1: add the y*recip pass
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [FRAC_W-1:0] divisor,
   input  logic [FRAC_W-1:0] dividend,
   output logic [FRAC_W+1:0] recip,
   output logic [FRAC_W+1:0] quot,
   output logic              done
);
   localparam int IW      = WORK_F + 2;
   localparam int RW      = FRAC_W + 2;
   localparam int SEED_SH = WORK_F - FRAC_W - SEED_F;
   localparam logic [IW-1:0] ONE = IW'(1) << WORK_F;

   // elaboration-time parameter checks
   if (FRAC_W + SEED_F > WORK_F) begin : g_bad_seed_fit
      $error("recip_iter_unit: x*p does not fit the working fraction");
   end
   if (8 * SEED_ACC < FRAC_W) begin : g_bad_accuracy
      $error("recip_iter_unit: three passes cannot reach FRAC_W bits");
   end
   if (8 * SEED_ACC + 8 > WORK_F) begin : g_bad_guard
      $error("recip_iter_unit: too few guard bits in WORK_F");
   end
   if (SEED_ACC >= SEED_F || SEED_ACC >= SEED_IDX - 1) begin : g_bad_seed
      $error("recip_iter_unit: table too coarse for SEED_ACC");
   end

   recip_phase_e      phase_q;
   logic [FRAC_W-1:0] x_q, y_q;
   logic [IW-1:0]     a_q, b_q;
   logic [RW-1:0]     q_q;

   logic [SEED_F:0]   seed_p;
   logic [IW-1:0]     a_seed, b_seed, m_fac, a_next, b_next;
   logic [RW-1:0]     q_next;
   corr_sel_e         csel;
   logic              upd_a, upd_b, upd_q;

   // ---------------- starting estimate ----------------
   recip_seed_rom #(.IDX_W(SEED_IDX), .SEED_F(SEED_F)) u_seed (
      .idx  (x_q[FRAC_W-2 -: SEED_IDX-1]),
      .seed (seed_p)
   );

   assign a_seed = (IW'(x_q) * IW'(seed_p)) << SEED_SH;
   assign b_seed = IW'(seed_p) << (WORK_F - SEED_F);

   // ---------------- correction factor ----------------
   always_comb begin
      case (phase_q)
         PH_CORR1: csel = CSEL_FIRST;
         PH_CORR2: csel = CSEL_SECOND;
         default:  csel = CSEL_THIRD;
      endcase
   end

   recip_corr_factor #(.FW(WORK_F), .SEED_ACC(SEED_ACC)) u_factor (
      .sel      (csel),
      .run_prod (a_q),
      .factor   (m_fac)
   );

   assign upd_a = (phase_q == PH_CORR1) || (phase_q == PH_CORR2);
   assign upd_b = upd_a || (phase_q == PH_CORR3);
   assign upd_q = (phase_q == PH_QUOT);

   // ---------------- shared-factor lanes ----------------
   recip_fix_mul #(.AW(IW), .BW(IW), .SH(WORK_F), .OW(IW)) u_mul_a (
      .clk (clk), .rst_n (rst_n), .chk (upd_a),
      .op_a (a_q), .op_b (m_fac), .prod (a_next)
   );

   recip_fix_mul #(.AW(IW), .BW(IW), .SH(WORK_F), .OW(IW)) u_mul_b (
      .clk (clk), .rst_n (rst_n), .chk (upd_b),
      .op_a (b_q), .op_b (m_fac), .prod (b_next)
   );

   if (WITH_QUOT != 0) begin : g_quot
      recip_fix_mul #(.AW(FRAC_W), .BW(IW), .SH(WORK_F), .OW(RW)) u_mul_q (
         .clk (clk), .rst_n (rst_n), .chk (upd_q),
         .op_a (y_q), .op_b (b_q), .prod (q_next)
      );
   end else begin : g_no_quot
      assign q_next = '0;
   end

   // ---------------- sequencer ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         x_q     <= '0;
         y_q     <= '0;
         a_q     <= '0;
         b_q     <= '0;
         q_q     <= '0;
      end else begin
         case (phase_q)
            PH_IDLE, PH_DONE: begin
               if (start) begin
                  x_q     <= divisor;
                  y_q     <= dividend;
                  phase_q <= PH_SEED;
               end else begin
                  phase_q <= PH_IDLE;
               end
            end
            PH_SEED: begin
               a_q     <= a_seed;
               b_q     <= b_seed;
               phase_q <= PH_CORR1;
            end
            PH_CORR1: begin
               a_q     <= a_next;
               b_q     <= b_next;
               phase_q <= PH_CORR2;
            end
            PH_CORR2: begin
               a_q     <= a_next;
               b_q     <= b_next;
               phase_q <= PH_CORR3;
            end
            PH_CORR3: begin
               b_q     <= b_next;   // running product is not needed any more
               phase_q <= (WITH_QUOT != 0) ? PH_QUOT : PH_DONE;
            end
            PH_QUOT: begin
               q_q     <= q_next;
               phase_q <= PH_DONE;
            end
            default: phase_q <= PH_IDLE;
         endcase
      end
   end

   assign recip = b_q[WORK_F+1 -: RW];
   assign quot  = q_q;
   assign done  = (phase_q == PH_DONE);

   // ---------------- assertions ----------------
   logic [IW-1:0] a_dev;
   assign a_dev = (a_q >= ONE) ? (a_q - ONE) : (ONE - a_q);

   // R3: table estimate puts x*p within 2^-SEED_ACC of one
   a_r3_seed_window: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_CORR1) |-> (a_dev < (ONE >> SEED_ACC)));

   // R3: first correction roughly squares the error
   a_r3_first_gain: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_CORR2) |-> (a_dev < (ONE >> (2*SEED_ACC - 1))));

   // R3: second correction squares it again
   a_r3_second_gain: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_CORR3) |-> (a_dev < (ONE >> (4*SEED_ACC - 1))));

   // R3: last pass leaves the running product untouched
   a_r3_last_keeps_a: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_CORR3) |=> $stable(a_q));

   // R2: done lasts one cycle
   a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R6: operands are frozen while a run is in flight
   a_r6_operand_held: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q != PH_IDLE && phase_q != PH_DONE) |=> ($stable(x_q) && $stable(y_q)));

   // R7: results hold while idle
   a_r7_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_IDLE) |=> ($stable(recip) && $stable(quot)));

endmodule

// File: tb/recip_iter_unit_bench.sv
module recip_iter_unit_bench;
   localparam int FW = 40;
   localparam int EXP_N = 6;  // negedges after the start-driving negedge: 5 edges + 1

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [FW-1:0] divisor = '0;
   logic [FW-1:0] dividend = '0;
   logic [FW+1:0] recip, quot;
   logic          done;

   int compared = 0;
   int mismatched = 0;

   always #2 clk = ~clk;

   recip_iter_unit u_recip_iter_unit (
      .clk (clk), .rst_n (rst_n), .start (start),
      .divisor (divisor), .dividend (dividend),
      .recip (recip), .quot (quot), .done (done)
   );

   task automatic report_and_end();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   endtask

   initial begin
      #(4 * 150000);
      compared++;
      mismatched++;
      $display("FAIL watchdog: run did not complete, got hang expected finish");
      report_and_end();
   end

   task automatic check_eq(input logic [63:0] got, input logic [63:0] exp, input string tag);
      compared++;
      if (got !== exp) begin
         mismatched++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   // |x*r - 1| < 2^-38, in units of 2^-80
   task automatic check_recip(input logic [FW-1:0] xv, input logic [FW+1:0] rv, input string tag);
      logic [83:0] prod, err, one;
      one  = 84'd1 << 80;
      prod = {44'd0, xv} * {42'd0, rv};
      err  = (prod >= one) ? prod - one : one - prod;
      compared++;
      if (err >= (84'd1 << 42)) begin
         mismatched++;
         $display("FAIL %s: error %0d /2^80 expected < %0d (x=%h recip=%h)",
                  tag, err, 84'd1 << 42, xv, rv);
      end
   endtask

   // |x*q - y| < 2^-37, in units of 2^-80
   task automatic check_quot(input logic [FW-1:0] xv, input logic [FW-1:0] yv,
                             input logic [FW+1:0] qv, input string tag);
      logic [83:0] lhs, rhs, err;
      lhs = {44'd0, xv} * {42'd0, qv};
      rhs = {4'd0, yv, 40'd0};
      err = (lhs >= rhs) ? lhs - rhs : rhs - lhs;
      compared++;
      if (err >= (84'd1 << 43)) begin
         mismatched++;
         $display("FAIL %s: error %0d /2^80 expected < %0d (x=%h y=%h quot=%h)",
                  tag, err, 84'd1 << 43, xv, yv, qv);
      end
   endtask

   // Drive a start at the current negedge; optionally inject a stray start.
   task automatic run_one(input logic [FW-1:0] xv, input logic [FW-1:0] yv,
                          input bit stray, output int lat);
      divisor  = xv;
      dividend = yv;
      start    = 1'b1;
      lat      = -1;
      for (int n = 1; n <= 30; n++) begin
         @(negedge clk);
         if (n == 1) start = 1'b0;
         if (stray && n == 2) begin
            start   = 1'b1;
            divisor = ~xv | 40'h80_0000_0000;
         end
         if (stray && n == 3) start = 1'b0;
         if (done) begin
            lat = n;
            break;
         end
      end
   endtask

   function automatic logic [FW-1:0] rand_x();
      return {1'b1, 7'($urandom), $urandom};
   endfunction

   function automatic logic [FW-1:0] rand_y();
      return {8'($urandom), $urandom};
   endfunction

   initial begin
      int lat;
      logic [FW+1:0] r_keep, q_keep;
      logic [FW-1:0] xv, yv;
      void'($urandom(32'd20240611));

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      check_eq(64'(done),  64'd0, "R1 done after reset");
      check_eq(64'(recip), 64'd0, "R1 recip after reset");
      check_eq(64'(quot),  64'd0, "R1 quot after reset");

      // R4: range endpoints
      xv = 40'h80_0000_0000; yv = 40'hFF_FFFF_FFFF;
      run_one(xv, yv, 1'b0, lat);
      check_eq(64'(lat), 64'(EXP_N), "R2 latency x=1/2");
      check_recip(xv, recip, "R4 x=1/2");
      check_quot(xv, yv, quot, "R5 y max at x=1/2");

      xv = 40'hFF_FFFF_FFFF; yv = 40'h0;
      run_one(xv, yv, 1'b0, lat);
      check_recip(xv, recip, "R4 x=1-2^-40");
      check_eq(64'(quot), 64'd0, "R5 y=0 gives zero quotient");

      // R7: outputs hold, done stays low while idle
      r_keep = recip; q_keep = quot;
      repeat (4) @(negedge clk);
      check_eq(64'(done),  64'd0, "R7 done low while idle");
      check_eq(64'(recip), 64'(r_keep), "R7 recip held");
      check_eq(64'(quot),  64'(q_keep), "R7 quot held");

      // R6: stray start mid-run with another divisor on the input
      xv = 40'hA5_5A5A_1234; yv = 40'h3C_0000_0001;
      run_one(xv, yv, 1'b1, lat);
      check_eq(64'(lat), 64'(EXP_N), "R6 latency unaffected by stray start");
      check_recip(xv, recip, "R6 result for original divisor");
      check_quot(xv, yv, quot, "R6 quotient for original operands");
      r_keep = recip;
      begin
         int extra = 0;
         for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            if (done) extra++;
         end
         check_eq(64'(extra), 64'd0, "R6 no second done");
         check_eq(64'(recip), 64'(r_keep), "R7 recip held after stray run");
      end

      // R4: first and last code of every 1/128 interval, run back to back
      for (int k = 64; k < 128; k++) begin
         xv = 40'(k) << 33;
         yv = rand_y();
         run_one(xv, yv, 1'b0, lat);
         check_recip(xv, recip, "R4 interval start");
         xv = (40'(k) << 33) | 40'h1_FFFF_FFFF;
         run_one(xv, yv, 1'b0, lat);   // R2: accepted in the done cycle
         check_eq(64'(lat), 64'(EXP_N), "R2 back-to-back latency");
         check_recip(xv, recip, "R4 interval end");
         check_quot(xv, yv, quot, "R5 interval end quotient");
      end

      // R3, R5: constrained-random normalized divisors
      for (int t = 0; t < 60; t++) begin
         xv = rand_x();
         yv = rand_y();
         if (t % 3 == 0) @(negedge clk);   // mix idle gaps with back-to-back runs
         run_one(xv, yv, 1'b0, lat);
         check_eq(64'(lat), 64'(EXP_N), "R2 latency random");
         check_recip(xv, recip, "R3 random divisor");
         check_quot(xv, yv, quot, "R5 random quotient");
      end

      @(negedge clk);
      report_and_end();
   end

endmodule